// File: doc/BRIEF.md
# Ethernet MAC FIFO Threshold Controller

This block holds the byte-wide transmit and receive FIFOs of a 10 Mb/s Ethernet MAC and turns their fill levels into control decisions. The host side writes transmit bytes and reads receive bytes. The MAC side reads transmit bytes and writes receive bytes. Every stored byte carries an end-of-frame marker. A programmable start point tells the serialiser when it may begin sending a frame. Two programmable watermarks raise request flags: one when the transmit FIFO has room for more host data, and one when the receive FIFO holds enough bytes for a host transfer.

Configuration arrives as two bytes, each written with a strobe. The bus configuration byte selects the transmit start point. The FIFO configuration byte carries both watermarks and the enable bits that guard them. The request flags are reported in a poll byte. The number of complete frames held in each direction is reported in a frame count byte. The serialiser, the CRC logic, DMA and bus arbitration are all outside this block.

Top module: `macfifo_ctrl`

## Requirements
- R1: After reset both FIFOs are empty and the frame count byte is 0x00. The transmit start point is 4 bytes, the transmit watermark is 8 words and the receive watermark is 16 bytes. So the poll byte reads 0x40 and `tx_start` is low.
- R2: Each FIFO returns bytes in the order they were written. The end-of-frame marker stays with its byte. The head byte and its marker are visible on the pop outputs without waiting a cycle.
- R3: A push into a full FIFO is dropped and does not change the contents. A pop from an empty FIFO has no effect.
- R4: Bits [5:4] of the bus configuration byte select the transmit start point: 00 is 4 bytes, 01 is 16, 10 is 64 and 11 is 112. `tx_start` goes high when the transmit FIFO holds at least that many bytes.
- R5: `tx_start` is also high whenever at least one complete frame is held in the transmit FIFO, whatever the byte count.
- R6: Bits [7:6] of the FIFO configuration byte select the transmit watermark, counted in 2-byte words: 00 is 8 words free, 01 is 16, 10 is 32, and 11 acts as 32. Poll bit 6 is high while the free words are at or above the watermark.
- R7: Bits [5:4] of the FIFO configuration byte select the receive watermark: 00 is 16 bytes, 01 is 32, 10 is 64, and 11 acts as 64. Poll bit 5 is high while the stored bytes are at or above the watermark. All other poll bits read 0.
- R8: A write of the FIFO configuration byte loads the transmit watermark only when bit 3 of that byte is 1, and loads the receive watermark only when bit 2 is 1. Otherwise the matching field is ignored.
- R9: The frame count byte reports the receive frame count in bits [7:4] and the transmit frame count in bits [3:0]. A count goes up when an end-of-frame byte is accepted into its FIFO and goes down when that byte leaves the FIFO.
- R10: A reported frame count stops at 15. The true count is still kept internally, so after pops the report falls back to the exact number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_cfg_wr | input | 1 | Write strobe for the bus configuration byte |
| bus_cfg_byte | input | 8 | Bus configuration byte (start point in [5:4]) |
| fifo_cfg_wr | input | 1 | Write strobe for the FIFO configuration byte |
| fifo_cfg_byte | input | 8 | FIFO configuration byte (watermarks and update enables) |
| tx_push | input | 1 | Host writes a transmit byte |
| tx_push_data | input | 8 | Transmit byte from the host |
| tx_push_eof | input | 1 | Transmit byte ends a frame |
| tx_full | output | 1 | Transmit FIFO full |
| tx_pop | input | 1 | Serialiser takes the head transmit byte |
| tx_pop_data | output | 8 | Head transmit byte |
| tx_pop_eof | output | 1 | Head transmit byte ends a frame |
| tx_empty | output | 1 | Transmit FIFO empty |
| tx_start | output | 1 | Serialiser may begin a frame |
| rx_push | input | 1 | MAC writes a received byte |
| rx_push_data | input | 8 | Received byte from the MAC |
| rx_push_eof | input | 1 | Received byte ends a frame |
| rx_full | output | 1 | Receive FIFO full |
| rx_pop | input | 1 | Host takes the head receive byte |
| rx_pop_data | output | 8 | Head receive byte |
| rx_pop_eof | output | 1 | Head receive byte ends a frame |
| rx_empty | output | 1 | Receive FIFO empty |
| poll_byte | output | 8 | Bit 6 is the transmit data request, bit 5 is the receive transfer request |
| frame_count_byte | output | 8 | Receive frames in [7:4], transmit frames in [3:0] |

## Verification
The assertions check on every cycle that the transmit byte count never exceeds the depth, that a blocked push or pop leaves the FIFO unchanged, that a configuration write without its enable bit leaves each watermark as it was, and that an accepted end-of-frame byte raises the transmit frame count by one. Some behaviour only the directed scenarios can show: byte order through each FIFO, the exact fill level at which each start-point and watermark code switches its flag, a complete short frame forcing a start, and the reported count stopping at 15 and then returning to the exact value.

// File: rtl/macfifo_pkg.sv
package macfifo_pkg;

    typedef logic [1:0] sel_t;

    // transmit start point in bytes
    function automatic int start_bytes(sel_t s);
        case (s)
            2'b00:   return 4;
            2'b01:   return 16;
            2'b10:   return 64;
            default: return 112;
        endcase
    endfunction

    // transmit watermark in free words; code 11 treated as largest legal
    function automatic int tx_mark_words(sel_t s);
        case (s)
            2'b00:   return 8;
            2'b01:   return 16;
            default: return 32;
        endcase
    endfunction

    // receive watermark in stored bytes; code 11 treated as largest legal
    function automatic int rx_mark_bytes(sel_t s);
        case (s)
            2'b00:   return 16;
            2'b01:   return 32;
            default: return 64;
        endcase
    endfunction

    function automatic logic [3:0] sat_nibble(int n);
        return (n > 15) ? 4'hF : n[3:0];
    endfunction

endpackage

// File: rtl/mf_byte_fifo.sv
module mf_byte_fifo #(
    parameter int DEPTH = 128,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          push_eof,
    input  logic          pop,
    output logic [DW-1:0] pop_data,
    output logic          pop_eof,
    output logic [CW-1:0] count,
    output logic [CW-1:0] frames,
    output logic          full,
    output logic          empty
);

    typedef struct packed {
        logic [AW-1:0] wr;
        logic [AW-1:0] rd;
        logic [CW-1:0] cnt;
        logic [CW-1:0] frm;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic [DW:0] mem_q [DEPTH];
    logic do_push, do_pop, head_eof;

    assign full     = (st_q.cnt == CW'(DEPTH));
    assign empty    = (st_q.cnt == '0);
    assign do_push  = push && !full;
    assign do_pop   = pop && !empty;
    assign head_eof = mem_q[st_q.rd][DW];

    function automatic logic [AW-1:0] nxt(logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d = st_q;
        if (do_push) st_d.wr = nxt(st_q.wr);
        if (do_pop)  st_d.rd = nxt(st_q.rd);
        case ({do_push, do_pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
        case ({do_push && push_eof, do_pop && head_eof})
            2'b10:   st_d.frm = st_q.frm + 1'b1;
            2'b01:   st_d.frm = st_q.frm - 1'b1;
            default: st_d.frm = st_q.frm;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[st_q.wr] <= {push_eof, push_data};
    end

    assign pop_data = mem_q[st_q.rd][DW-1:0];
    assign pop_eof  = head_eof;
    assign count    = st_q.cnt;
    assign frames   = st_q.frm;

endmodule

// File: rtl/mf_cfg_regs.sv
module mf_cfg_regs
    import macfifo_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_wr,
    input  logic [7:0] bus_byte,
    input  logic       fifo_wr,
    input  logic [7:0] fifo_byte,
    output sel_t       start_sel,
    output sel_t       txmark_sel,
    output sel_t       rxmark_sel
);

    typedef struct packed {
        sel_t start;
        sel_t txm;
        sel_t rxm;
    } cfg_st_t;

    cfg_st_t cfg_d, cfg_q;
    logic unused_cfg_bits;

    assign unused_cfg_bits = ^{bus_byte[7:6], bus_byte[3:0], fifo_byte[1:0]};

    always_comb begin
        cfg_d = cfg_q;
        if (bus_wr) cfg_d.start = bus_byte[5:4];
        if (fifo_wr && fifo_byte[3]) cfg_d.txm = fifo_byte[7:6];
        if (fifo_wr && fifo_byte[2]) cfg_d.rxm = fifo_byte[5:4];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign start_sel  = cfg_q.start;
    assign txmark_sel = cfg_q.txm;
    assign rxmark_sel = cfg_q.rxm;

endmodule

// File: rtl/macfifo_ctrl.sv
module macfifo_ctrl
    import macfifo_pkg::*;
#(
    parameter int DEPTH      = 128,
    parameter int WORD_BYTES = 2,
    localparam int CW        = $clog2(DEPTH + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_cfg_wr,
    input  logic [7:0] bus_cfg_byte,
    input  logic       fifo_cfg_wr,
    input  logic [7:0] fifo_cfg_byte,
    input  logic       tx_push,
    input  logic [7:0] tx_push_data,
    input  logic       tx_push_eof,
    output logic       tx_full,
    input  logic       tx_pop,
    output logic [7:0] tx_pop_data,
    output logic       tx_pop_eof,
    output logic       tx_empty,
    output logic       tx_start,
    input  logic       rx_push,
    input  logic [7:0] rx_push_data,
    input  logic       rx_push_eof,
    output logic       rx_full,
    input  logic       rx_pop,
    output logic [7:0] rx_pop_data,
    output logic       rx_pop_eof,
    output logic       rx_empty,
    output logic [7:0] poll_byte,
    output logic [7:0] frame_count_byte
);

    logic [CW-1:0] tx_cnt, tx_frm, rx_cnt, rx_frm;
    sel_t start_sel, txmark_sel, rxmark_sel;
    int   tx_free_words;
    logic tx_req, rx_req;

    mf_cfg_regs u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr     (bus_cfg_wr),
        .bus_byte   (bus_cfg_byte),
        .fifo_wr    (fifo_cfg_wr),
        .fifo_byte  (fifo_cfg_byte),
        .start_sel  (start_sel),
        .txmark_sel (txmark_sel),
        .rxmark_sel (rxmark_sel)
    );

    mf_byte_fifo #(.DEPTH(DEPTH), .DW(8)) u_txf (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (tx_push),
        .push_data (tx_push_data),
        .push_eof  (tx_push_eof),
        .pop       (tx_pop),
        .pop_data  (tx_pop_data),
        .pop_eof   (tx_pop_eof),
        .count     (tx_cnt),
        .frames    (tx_frm),
        .full      (tx_full),
        .empty     (tx_empty)
    );

    mf_byte_fifo #(.DEPTH(DEPTH), .DW(8)) u_rxf (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (rx_push),
        .push_data (rx_push_data),
        .push_eof  (rx_push_eof),
        .pop       (rx_pop),
        .pop_data  (rx_pop_data),
        .pop_eof   (rx_pop_eof),
        .count     (rx_cnt),
        .frames    (rx_frm),
        .full      (rx_full),
        .empty     (rx_empty)
    );

    always_comb begin
        tx_free_words = (DEPTH - int'(tx_cnt)) / WORD_BYTES;
        tx_req   = (tx_free_words >= tx_mark_words(txmark_sel));
        rx_req   = (int'(rx_cnt) >= rx_mark_bytes(rxmark_sel));
        tx_start = (int'(tx_cnt) >= start_bytes(start_sel)) || (tx_frm != '0);
        poll_byte        = {1'b0, tx_req, rx_req, 5'b0};
        frame_count_byte = {sat_nibble(int'(rx_frm)), sat_nibble(int'(tx_frm))};
    end

endmodule

// File: rtl/macfifo_ctrl_chk.sv
module macfifo_ctrl_chk #(
    parameter int DEPTH = 128,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          fifo_cfg_wr,
    input logic [7:0]    fifo_cfg_byte,
    input logic          tx_push,
    input logic          tx_push_eof,
    input logic          tx_full,
    input logic          tx_pop,
    input logic          tx_pop_eof,
    input logic          tx_empty,
    input logic          rx_push,
    input logic          rx_pop,
    input logic          rx_empty,
    input logic [CW-1:0] tx_cnt,
    input logic [CW-1:0] tx_frm,
    input logic [1:0]    txmark_sel,
    input logic [1:0]    rxmark_sel
);

    a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        int'(tx_cnt) <= DEPTH);

    a_r3_full_push_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        tx_full && tx_push && !tx_pop |=> tx_cnt == $past(tx_cnt));

    a_r3_empty_pop_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        rx_empty && rx_pop && !rx_push |=> rx_empty);

    a_r8_txmark_guarded: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_cfg_wr && !fifo_cfg_byte[3] |=> $stable(txmark_sel));

    a_r8_rxmark_guarded: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_cfg_wr && !fifo_cfg_byte[2] |=> $stable(rxmark_sel));

    a_r9_tx_frame_up: assert property (@(posedge clk) disable iff (!rst_n)
        tx_push && tx_push_eof && !tx_full && !(tx_pop && !tx_empty && tx_pop_eof)
        |=> tx_frm == $past(tx_frm) + 1'b1);

endmodule

bind macfifo_ctrl macfifo_ctrl_chk #(.DEPTH(DEPTH)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .fifo_cfg_wr   (fifo_cfg_wr),
    .fifo_cfg_byte (fifo_cfg_byte),
    .tx_push       (tx_push),
    .tx_push_eof   (tx_push_eof),
    .tx_full       (tx_full),
    .tx_pop        (tx_pop),
    .tx_pop_eof    (tx_pop_eof),
    .tx_empty      (tx_empty),
    .rx_push       (rx_push),
    .rx_pop        (rx_pop),
    .rx_empty      (rx_empty),
    .tx_cnt        (tx_cnt),
    .tx_frm        (tx_frm),
    .txmark_sel    (txmark_sel),
    .rxmark_sel    (rxmark_sel)
);

// File: tb/sim_macfifo_ctrl.sv
module sim_macfifo_ctrl;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic       bus_cfg_wr = 0;
    logic [7:0] bus_cfg_byte = 0;
    logic       fifo_cfg_wr = 0;
    logic [7:0] fifo_cfg_byte = 0;
    logic       tx_push = 0, tx_push_eof = 0, tx_pop = 0;
    logic [7:0] tx_push_data = 0;
    logic       rx_push = 0, rx_push_eof = 0, rx_pop = 0;
    logic [7:0] rx_push_data = 0;
    logic       tx_full, tx_pop_eof, tx_empty, tx_start;
    logic       rx_full, rx_pop_eof, rx_empty;
    logic [7:0] tx_pop_data, rx_pop_data, poll_byte, frame_count_byte;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    macfifo_ctrl u0 (
        .clk(clk), .rst_n(rst_n),
        .bus_cfg_wr(bus_cfg_wr), .bus_cfg_byte(bus_cfg_byte),
        .fifo_cfg_wr(fifo_cfg_wr), .fifo_cfg_byte(fifo_cfg_byte),
        .tx_push(tx_push), .tx_push_data(tx_push_data), .tx_push_eof(tx_push_eof),
        .tx_full(tx_full), .tx_pop(tx_pop), .tx_pop_data(tx_pop_data),
        .tx_pop_eof(tx_pop_eof), .tx_empty(tx_empty), .tx_start(tx_start),
        .rx_push(rx_push), .rx_push_data(rx_push_data), .rx_push_eof(rx_push_eof),
        .rx_full(rx_full), .rx_pop(rx_pop), .rx_pop_data(rx_pop_data),
        .rx_pop_eof(rx_pop_eof), .rx_empty(rx_empty),
        .poll_byte(poll_byte), .frame_count_byte(frame_count_byte)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // all drivers change at negedge; state updates at the following posedge
    task automatic tx_put(input logic [7:0] d, input logic eof);
        @(negedge clk);
        tx_push = 1; tx_push_data = d; tx_push_eof = eof;
        @(negedge clk);
        tx_push = 0; tx_push_eof = 0;
    endtask

    task automatic rx_put(input logic [7:0] d, input logic eof);
        @(negedge clk);
        rx_push = 1; rx_push_data = d; rx_push_eof = eof;
        @(negedge clk);
        rx_push = 0; rx_push_eof = 0;
    endtask

    task automatic tx_take(output logic [7:0] d, output logic eof);
        @(negedge clk);
        d = tx_pop_data; eof = tx_pop_eof;
        tx_pop = 1;
        @(negedge clk);
        tx_pop = 0;
    endtask

    task automatic rx_take(output logic [7:0] d, output logic eof);
        @(negedge clk);
        d = rx_pop_data; eof = rx_pop_eof;
        rx_pop = 1;
        @(negedge clk);
        rx_pop = 0;
    endtask

    task automatic wr_bus(input logic [7:0] b);
        @(negedge clk); bus_cfg_wr = 1; bus_cfg_byte = b;
        @(negedge clk); bus_cfg_wr = 0;
    endtask

    task automatic wr_fifo(input logic [7:0] b);
        @(negedge clk); fifo_cfg_wr = 1; fifo_cfg_byte = b;
        @(negedge clk); fifo_cfg_wr = 0;
    endtask

    task automatic drain_all();
        logic [7:0] d; logic e;
        for (int i = 0; i < 200 && !tx_empty; i++) tx_take(d, e);
        for (int i = 0; i < 200 && !rx_empty; i++) rx_take(d, e);
    endtask

    task automatic t_reset();
        check("R1 tx_empty", int'(tx_empty), 1);
        check("R1 rx_empty", int'(rx_empty), 1);
        check("R1 frame count", int'(frame_count_byte), 8'h00);
        check("R1 poll", int'(poll_byte), 8'h40);
        check("R1 tx_start", int'(tx_start), 0);
    endtask

    task automatic t_order();
        logic [7:0] d; logic e;
        rx_put(8'hA1, 0); rx_put(8'hB2, 0); rx_put(8'hC3, 1);
        check("R9 rx frame nibble", int'(frame_count_byte), 8'h10);
        rx_take(d, e); check("R2 data0", int'(d), 8'hA1); check("R2 eof0", int'(e), 0);
        rx_take(d, e); check("R2 data1", int'(d), 8'hB2); check("R2 eof1", int'(e), 0);
        rx_take(d, e); check("R2 data2", int'(d), 8'hC3); check("R2 eof2", int'(e), 1);
        check("R2 empty after", int'(rx_empty), 1);
        check("R9 rx frame down", int'(frame_count_byte), 8'h00);
    endtask

    task automatic t_empty_pop();
        logic [7:0] d; logic e;
        for (int i = 0; i < 3; i++) tx_take(d, e);
        check("R3 empty pop keeps empty", int'(tx_empty), 1);
        tx_put(8'h5A, 0);
        tx_take(d, e);
        check("R3 data after empty pops", int'(d), 8'h5A);
        check("R3 empty again", int'(tx_empty), 1);
    endtask

    task automatic t_full();
        logic [7:0] d; logic e;
        int bad = 0;
        for (int i = 0; i < 128; i++) tx_put(8'(i), 0);
        check("R3 full flag", int'(tx_full), 1);
        tx_put(8'hEE, 0);
        check("R3 still full", int'(tx_full), 1);
        for (int i = 0; i < 128; i++) begin
            tx_take(d, e);
            if (d != 8'(i)) bad++;
        end
        check("R3 full order mismatches", bad, 0);
        check("R3 dropped byte absent", int'(tx_empty), 1);
    endtask

    task automatic t_start_points();
        int thr [4] = '{4, 16, 64, 112};
        for (int c = 0; c < 4; c++) begin
            wr_bus(8'(c << 4));
            for (int i = 0; i < thr[c] - 1; i++) tx_put(8'h33, 0);
            check($sformatf("R4 below start code %0d", c), int'(tx_start), 0);
            tx_put(8'h33, 0);
            check($sformatf("R4 at start code %0d", c), int'(tx_start), 1);
            drain_all();
        end
    endtask

    task automatic t_start_frame();
        wr_bus(8'h30);
        tx_put(8'h11, 0);
        check("R5 no frame yet", int'(tx_start), 0);
        tx_put(8'h22, 1);
        check("R5 frame forces start", int'(tx_start), 1);
        check("R9 tx frame nibble", int'(frame_count_byte), 8'h01);
        drain_all();
        check("R9 tx frame back to 0", int'(frame_count_byte), 8'h00);
        wr_bus(8'h00);
    endtask

    task automatic t_tx_mark();
        logic [7:0] d; logic e;
        wr_fifo(8'h48);                         // code 01, enabled: 16 words
        for (int i = 0; i < 96; i++) tx_put(8'h44, 0);
        check("R6 16 words free", int'(poll_byte[6]), 1);
        wr_fifo(8'h80);                         // code 10 without enable
        check("R8 tx mark ignored", int'(poll_byte[6]), 1);
        tx_put(8'h44, 0);
        check("R6 15 words free", int'(poll_byte[6]), 0);
        wr_fifo(8'hC8);                         // code 11 acts as 32 words
        for (int i = 0; i < 33; i++) tx_take(d, e);
        check("R6 code11 32 words free", int'(poll_byte[6]), 1);
        tx_put(8'h44, 0);
        check("R6 code11 31 words free", int'(poll_byte[6]), 0);
        drain_all();
        wr_fifo(8'h08);
    endtask

    task automatic t_rx_mark();
        logic [7:0] d; logic e;
        for (int i = 0; i < 15; i++) rx_put(8'h55, 0);
        check("R7 15 bytes code00", int'(poll_byte[5]), 0);
        rx_put(8'h55, 0);
        check("R7 16 bytes code00", int'(poll_byte[5]), 1);
        wr_fifo(8'h24);                         // code 10, enabled
        check("R7 16 bytes code10", int'(poll_byte[5]), 0);
        for (int i = 0; i < 47; i++) rx_put(8'h55, 0);
        check("R7 63 bytes code10", int'(poll_byte[5]), 0);
        rx_put(8'h55, 0);
        check("R7 64 bytes code10", int'(poll_byte[5]), 1);
        wr_fifo(8'h34);                         // code 11 acts as 64
        check("R7 64 bytes code11", int'(poll_byte[5]), 1);
        rx_take(d, e);
        check("R7 63 bytes code11", int'(poll_byte[5]), 0);
        wr_fifo(8'h00);                         // code 00 without enable
        check("R8 rx mark ignored", int'(poll_byte[5]), 0);
        check("R7 other poll bits zero", int'(poll_byte & 8'h9F), 0);
        drain_all();
    endtask

    task automatic t_frames();
        logic [7:0] d; logic e;
        for (int i = 0; i < 3; i++) rx_put(8'(i), 1);
        for (int i = 0; i < 20; i++) tx_put(8'(i), 1);
        check("R10 tx saturates, rx 3", int'(frame_count_byte), 8'h3F);
        for (int i = 0; i < 6; i++) tx_take(d, e);
        check("R10 tx exact 14 after pops", int'(frame_count_byte), 8'h3E);
        drain_all();
        check("R9 both zero", int'(frame_count_byte), 8'h00);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_order();
        t_empty_pop();
        t_full();
        t_start_points();
        t_start_frame();
        t_tx_mark();
        t_rx_mark();
        t_frames();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule